// File: doc/BRIEF.md
# Decimal Fixed-Point to Single-Precision Float Converter

This block turns a number written as a signed binary integer part and a decimal fractional part into a 32-bit IEEE-754 single-precision bit pattern. The fractional operand is an unsigned integer that holds the decimal digits found after the point, so an operand of 25 means .25 and an operand of 5 means .5. The block works on one operand pair at a time. Software or a controlling state machine raises `start` for one cycle with both operands valid. It then waits for the one-cycle `done` pulse and reads `result`.

Internally the block takes the magnitude of the integer part. It scales the fractional digits against the next power of ten and expands them into binary fraction bits, one doubling step per clock. The integer and fraction bits are joined into one wide word. The block finds the leading one of that word, takes the exponent from its position, and left-aligns the bits below it into the 23-bit mantissa. Any dropped 1 bits are folded into the mantissa LSB. Denormals, infinities, NaNs and round-to-nearest-even are never produced.

Top module: `fdec2fp`

## Requirements
- R1: When bit 31 of `int_in` is 1, the operand is a negative two's-complement value. `result[31]` is then 1, and the magnitude used is the two's-complement negation, so -2147483648 gives magnitude 2^31. For a non-negative operand `result[31]` is 0.
- R2: `result[30:23]` holds 127 + e, where e is the position of the leading one of the value. For a non-zero integer magnitude, e is the bit index of its leading one, counted from bit 0. When the integer magnitude is zero, e is minus the position of the first 1 after the binary point, where the first bit after the point is position 1.
- R3: `result[22:0]` holds the bits that follow the leading one, most significant first. The integer bits below the leading one come first, and the binary fraction bits follow directly beneath them.
- R4: A fractional operand f stands for f / 10^k, where 10^k is the smallest power of ten strictly greater than f. This value is expanded into exactly 32 binary fraction bits, truncated: the floor of f * 2^32 / 10^k.
- R5: If any 1 bit of the joined integer and fraction bits falls below the 23 mantissa bits, `result[0]` is forced to 1. Otherwise the truncated bits are used as they are.
- R6: When the integer and fractional operands are both zero, `result` is 32'h00000000.
- R7: A fractional operand greater than 999,999,999 is treated as 999,999,999.
- R8: `start` is accepted on a rising edge where `busy` is low. `busy` is high from that edge through the 34th rising edge after it. `done` is high for exactly one cycle, beginning at that 34th edge, and `busy` is low while `done` is high.
- R9: `start` is ignored while `busy` is high. The conversion under way keeps its operands and its timing.
- R10: After reset, `busy` and `done` are low and `result` is zero. `result` changes only at the edge that raises `done`, and it holds its value until the next such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a conversion with the operands present this cycle |
| int_in | input | 32 | Integer part, two's complement |
| frac_in | input | 30 | Fractional part as a decimal-digit integer |
| busy | output | 1 | A conversion is under way |
| done | output | 1 | One-cycle pulse, `result` is new |
| result | output | 32 | Single-precision bit pattern |

## Verification
Each conversion's result is due 34 rising edges after the edge that accepts `start`. The bench samples all outputs at the falling edge that follows. A behavioural model in the bench counts those same 34 edges from each accepted start. At every falling edge it compares `busy`, `done` and `result` with its own prediction, so a pulse one cycle early or late, or a start that is accepted when it should not be, shows up as a mismatch in that cycle. The value the model predicts comes from integer arithmetic that follows the requirements. Directed operands whose single-precision patterns were worked out by hand confirm it separately.

// File: rtl/fdec2fp_pkg.sv
// Shared constants, FSM state type and a constant power-of-ten helper for
// the decimal fixed-point to single-precision converter.
package fdec2fp_pkg;

    localparam int EXP_BIAS = 127;
    localparam int EXP_W    = 8;
    localparam int MANT_W   = 23;
    localparam int WORD_W   = 1 + EXP_W + MANT_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCALE,
        ST_DOUBLE,
        ST_PACK
    } cvt_state_t;

    // 10 to the power k, for elaboration-time tables
    function automatic longint unsigned pow10(input int k);
        longint unsigned v;
        v = 1;
        for (int i = 0; i < k; i++) begin
            v = v * 10;
        end
        return v;
    endfunction

endpackage

// File: rtl/fdec2fp_pow10.sv
// Picks the smallest power of ten strictly greater than the input value.
// Assumes value <= 10^DEC_DIGITS - 1 and that 10^DEC_DIGITS fits in FRAC_W bits.
// A zero input selects 10^0 = 1.
module fdec2fp_pow10
    import fdec2fp_pkg::*;
#(
    parameter int FRAC_W     = 30,
    parameter int DEC_DIGITS = 9
) (
    input  logic [FRAC_W-1:0] value,
    output logic [FRAC_W-1:0] scale
);

    logic [FRAC_W-1:0] ladder [DEC_DIGITS+1];

    genvar gk;
    generate
        for (gk = 0; gk <= DEC_DIGITS; gk++) begin : g_ladder
            assign ladder[gk] = FRAC_W'(pow10(gk));
        end
    endgenerate

    // Walk down the ladder so the last hit is the smallest power above value
    always_comb begin
        scale = ladder[DEC_DIGITS];
        for (int k = DEC_DIGITS - 1; k >= 0; k--) begin
            if (value < ladder[k]) begin
                scale = ladder[k];
            end
        end
    end

endmodule

// File: rtl/fdec2fp_doubler.sv
// Expands remainder/scale into binary fraction bits, one bit per step.
// Each step doubles the remainder. When the doubled value reaches the scale,
// the step emits a 1 and subtracts the scale; otherwise it emits a 0.
// Bits enter at the LSB, so after FB steps the first bit sits at the MSB.
// Assumes value < scale when load is applied.
module fdec2fp_doubler #(
    parameter int FRAC_W = 30,
    parameter int FB     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [FRAC_W-1:0] value,
    input  logic [FRAC_W-1:0] scale,
    output logic [FB-1:0]     bits
);

    logic [FRAC_W-1:0] rem_q;
    logic [FRAC_W-1:0] scale_q;
    logic [FRAC_W:0]   twice;
    logic [FRAC_W:0]   less;
    logic              hit;

    // Doubled remainder, the trial subtraction and the emitted bit
    always_comb begin
        twice = {rem_q, 1'b0};
        less  = twice - {1'b0, scale_q};
        hit   = (twice >= {1'b0, scale_q});
    end

    // Remainder, scale and fraction shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            scale_q <= '0;
            bits    <= '0;
        end else if (load) begin
            rem_q   <= value;
            scale_q <= scale;
            bits    <= '0;
        end else if (step) begin
            rem_q   <= hit ? less[FRAC_W-1:0] : twice[FRAC_W-1:0];
            bits    <= {bits[FB-2:0], hit};
        end
    end

endmodule

// File: rtl/fdec2fp_normpack.sv
// Joins the integer magnitude and the binary fraction into one word, finds its
// leading one, and packs sign, biased exponent and mantissa. Ones below the
// mantissa are folded into the mantissa LSB. An all-zero word packs to zero.
// Assumes a non-zero fraction has a 1 within its top four bits
// (the fraction is always at least 0.1).
module fdec2fp_normpack
    import fdec2fp_pkg::*;
#(
    parameter int INT_W = 32,
    parameter int FB    = 32
) (
    input  logic               sign,
    input  logic [INT_W-1:0]   mag,
    input  logic [FB-1:0]      fbits,
    output logic [WORD_W-1:0]  word
);

    localparam int WW = INT_W + FB;
    localparam int QW = $clog2(WW);

    logic [WW-1:0]     joined;
    logic [WW-1:0]     aligned;
    logic [QW-1:0]     lead;
    logic              nonzero;
    logic [MANT_W-1:0] mant;
    logic              sticky;
    logic [EXP_W-1:0]  expo;

    // Leading-one position of the joined word
    always_comb begin
        joined  = {mag, fbits};
        nonzero = |joined;
        lead    = '0;
        for (int i = 0; i < WW; i++) begin
            if (joined[i]) begin
                lead = QW'(i);
            end
        end
    end

    // Move the leading one to the top bit and split mantissa from sticky bits
    always_comb begin
        aligned = joined << (QW'(WW - 1) - lead);
        mant    = aligned[WW-2 -: MANT_W];
        sticky  = |aligned[WW-2-MANT_W:0];
        expo    = EXP_W'(EXP_BIAS - FB + int'(lead));
    end

    // Final word; zero magnitude packs to all zeros
    always_comb begin
        if (nonzero) begin
            word = {sign, expo, mant[MANT_W-1:1], mant[0] | sticky};
        end else begin
            word = '0;
        end
    end

endmodule

// File: rtl/fdec2fp.sv
// Sequential converter from signed integer plus decimal-digit fraction to an
// IEEE-754 single-precision pattern. The FSM captures the operands, selects
// the scaling power of ten, runs FB doubling steps, then packs the word and
// pulses done. The operand layout assumes INT_W integer bits and FRAC_W
// fraction-operand bits; fraction operands above 10^DEC_DIGITS - 1 are clamped.
module fdec2fp
    import fdec2fp_pkg::*;
#(
    parameter int INT_W      = 32,
    parameter int FRAC_W     = 30,
    parameter int DEC_DIGITS = 9,
    parameter int FB         = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [INT_W-1:0]  int_in,
    input  logic [FRAC_W-1:0] frac_in,
    output logic              busy,
    output logic              done,
    output logic [31:0]       result
);

    localparam logic [FRAC_W-1:0] FRAC_MAX = FRAC_W'(pow10(DEC_DIGITS) - 1);
    localparam int                CW       = $clog2(FB);

    cvt_state_t         state;
    logic               sign_q;
    logic [INT_W-1:0]   mag_q;
    logic [FRAC_W-1:0]  frac_q;
    logic [CW-1:0]      step_cnt;
    logic [FRAC_W-1:0]  scale;
    logic [FB-1:0]      fbits;
    logic [WORD_W-1:0]  packed_word;
    logic               do_load;
    logic               do_step;

    // Datapath strobes decoded from the FSM state
    always_comb begin
        do_load = (state == ST_SCALE);
        do_step = (state == ST_DOUBLE);
        busy    = (state != ST_IDLE);
    end

    fdec2fp_pow10 #(
        .FRAC_W     (FRAC_W),
        .DEC_DIGITS (DEC_DIGITS)
    ) u_pow10 (
        .value (frac_q),
        .scale (scale)
    );

    fdec2fp_doubler #(
        .FRAC_W (FRAC_W),
        .FB     (FB)
    ) u_doubler (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (do_load),
        .step  (do_step),
        .value (frac_q),
        .scale (scale),
        .bits  (fbits)
    );

    fdec2fp_normpack #(
        .INT_W (INT_W),
        .FB    (FB)
    ) u_normpack (
        .sign  (sign_q),
        .mag   (mag_q),
        .fbits (fbits),
        .word  (packed_word)
    );

    // Conversion sequencer, operand capture and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sign_q   <= 1'b0;
            mag_q    <= '0;
            frac_q   <= '0;
            step_cnt <= '0;
            done     <= 1'b0;
            result   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        sign_q <= int_in[INT_W-1];
                        mag_q  <= int_in[INT_W-1] ? (~int_in) + INT_W'(1) : int_in;
                        frac_q <= (frac_in > FRAC_MAX) ? FRAC_MAX : frac_in;
                        state  <= ST_SCALE;
                    end
                end
                ST_SCALE: begin
                    step_cnt <= '0;
                    state    <= ST_DOUBLE;
                end
                ST_DOUBLE: begin
                    step_cnt <= step_cnt + CW'(1);
                    if (step_cnt == CW'(FB - 1)) begin
                        state <= ST_PACK;
                    end
                end
                ST_PACK: begin
                    result <= packed_word;
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fdec2fp_checker.sv
// Protocol and result-shape properties for fdec2fp, attached by bind.
// Keeps its own count of busy cycles so that the latency window needs no
// long $past chain.
module fdec2fp_checker
    import fdec2fp_pkg::*;
#(
    parameter int INT_W = 32,
    parameter int FB    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [INT_W-1:0] int_in,
    input logic             busy,
    input logic             done,
    input logic [31:0]      result
);

    localparam int LW = $clog2(FB + 4);

    logic [LW-1:0] busy_len;
    logic          sign_cap;

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (busy) begin
            busy_len <= busy_len + LW'(1);
        end else begin
            busy_len <= '0;
        end
    end

    // Remember the operand sign at the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_cap <= 1'b0;
        end else if (start && !busy) begin
            sign_cap <= int_in[INT_W-1];
        end
    end

    assert_sign_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result[30:0] != 31'd0)) |-> (result[31] == sign_cap));

    assert_exp_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result != 32'd0)) |->
            ((result[30:23] >= 8'(EXP_BIAS - 4)) && (result[30:23] <= 8'(EXP_BIAS + INT_W - 1))));

    assert_zero_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result[30:23] == 8'd0)) |-> (result == 32'd0));

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_len == LW'(FB + 2)));

    assert_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

endmodule

bind fdec2fp fdec2fp_checker #(
    .INT_W (INT_W),
    .FB    (FB)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .int_in (int_in),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/fdec2fp_tb.sv
// Self-checking bench: behavioural model of timing and value, compared on
// every falling edge, plus directed operands with hand-worked patterns.
module fdec2fp_tb;

    localparam int LAT = 34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] int_in = '0;
    logic [29:0] frac_in = '0;
    logic        busy;
    logic        done;
    logic [31:0] result;

    int n_chk = 0;
    int n_fail = 0;

    // model state
    bit          m_busy = 1'b0;
    bit          m_done = 1'b0;
    int          m_cnt = 0;
    logic [31:0] m_res = '0;
    logic [31:0] m_pend = '0;

    fdec2fp u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .int_in  (int_in),
        .frac_in (frac_in),
        .busy    (busy),
        .done    (done),
        .result  (result)
    );

    always #5 clk = ~clk;

    // Expected pattern from the requirements, in wide integer arithmetic
    function automatic logic [31:0] ref_word(input logic [31:0] iv, input logic [29:0] fv);
        longint unsigned mag, fr, p, fb, w, rest, low;
        int q;
        logic s;
        logic [22:0] m;
        logic [7:0] e;
        s   = iv[31];
        mag = s ? (64'h1_0000_0000 - {32'h0, iv}) : {32'h0, iv};
        fr  = (fv > 30'd999999999) ? 64'd999999999 : {34'h0, fv};
        p   = 1;
        while (p <= fr) p = p * 10;
        fb  = (fr << 32) / p;
        w   = (mag << 32) | fb;
        if (w == 0) return 32'h0;
        q = 63;
        while (!w[q]) q--;
        rest = w & ((64'd1 << q) - 1);
        m    = 23'(rest >> (q - 23));
        low  = rest & ((64'd1 << (q - 23)) - 1);
        if (low != 0) m[0] = 1'b1;
        e = 8'(127 + q - 32);
        return {s, e, m};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Timing and value model advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0;
            m_done = 1'b0;
            m_cnt  = 0;
            m_res  = '0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == LAT) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                    m_res  = m_pend;
                end
            end else if (start) begin
                m_busy = 1'b1;
                m_cnt  = 0;
                m_pend = ref_word(int_in, frac_in);
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_busy, "R8 busy", {31'h0, busy}, {31'h0, m_busy});
            chk(done == m_done, "R8 done", {31'h0, done}, {31'h0, m_done});
            chk(result == m_res, m_done ? "R4 value" : "R10 hold", result, m_res);
        end
    end

    task automatic launch(input logic [31:0] iv, input logic [29:0] fv);
        @(negedge clk);
        while (busy) @(negedge clk);
        int_in  = iv;
        frac_in = fv;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic convert_expect(input logic [31:0] iv, input logic [29:0] fv,
                                  input logic [31:0] exp, input string tag);
        launch(iv, fv);
        wait_done();
        chk(result == exp, tag, result, exp);
    endtask

    initial begin
        logic [31:0] first;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy == 1'b0, "R10 reset busy", {31'h0, busy}, 32'h0);
        chk(done == 1'b0, "R10 reset done", {31'h0, done}, 32'h0);
        chk(result == 32'h0, "R10 reset result", result, 32'h0);
        rst_n = 1'b1;

        convert_expect(32'd3, 30'd25, 32'h40500000, "R2 R3 R4 3.25");
        convert_expect(-32'sd3, 30'd25, 32'hC0500000, "R1 -3.25");
        convert_expect(32'd12, 30'd5, 32'h41480000, "R3 12.5");
        convert_expect(32'd0, 30'd5, 32'h3F000000, "R2 0.5 negative exponent");
        convert_expect(32'd0, 30'd1, 32'h3DCCCCCD, "R4 R5 0.1 sticky");
        convert_expect(32'd1, 30'd0, 32'h3F800000, "R2 1.0");
        convert_expect(32'd0, 30'd0, 32'h00000000, "R6 zero");
        convert_expect(32'h8000_0000, 30'd0, 32'hCF000000, "R1 most negative");
        convert_expect(32'd16777217, 30'd0, 32'h4B800001, "R5 integer sticky");

        // R7: over-range fraction matches the clamped limit
        convert_expect(32'd0, 30'd999999999, ref_word(32'd0, 30'd999999999), "R7 limit");
        first = result;
        convert_expect(32'd0, 30'h3FFFFFFF, first, "R7 clamp");

        // R9: start while busy is ignored
        launch(32'd5, 30'd5);
        repeat (3) @(negedge clk);
        int_in  = 32'd7;
        frac_in = 30'd7;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        wait_done();
        chk(result == 32'h40B00000, "R9 ignored start", result, 32'h40B00000);
        @(negedge clk);
        chk(busy == 1'b0, "R9 no second run", {31'h0, busy}, 32'h0);

        // Mixed operands against the model
        for (int k = 0; k < 40; k++) begin
            logic [31:0] iv;
            logic [29:0] fv;
            if (k % 3 == 0) iv = $urandom;
            else if (k % 3 == 1) iv = 32'($urandom_range(0, 300)) - 32'd150;
            else iv = 32'd0;
            if (k % 5 == 0) fv = 30'($urandom);
            else fv = 30'($urandom_range(0, 999999999));
            convert_expect(iv, fv, ref_word(iv, fv), "R3 R4 R5 mixed");
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        finish_run();
    end

endmodule